// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block is the hazard control that sits in the decode stage of a five-stage, in-order integer pipeline. Each cycle it takes the two source register numbers of the instruction being decoded. It compares them against the destination registers of the instructions currently in execute and in memory access. For each operand it picks one of three values: the register file read data, the result held in the execute stage register, or the value held in the access stage register. The access stage value is either loaded data or an ALU result passed along. The chosen operand is stored in a flop at the end of decode, and that flop drives the ALU on the following cycle. Single-cycle results travel on through the access stage, so every result reaches the register file in the same stage through a single write port.

An instruction may depend on a load that is still in execute. The loaded value does not exist yet, so the block raises `stall` for one cycle. While `stall` is high, the surrounding fetch and decode registers must hold their contents, and the block sends a no-op into execute: `x_valid` is low and `bubble` is high. On the next cycle the load has moved to access and its data is forwarded from there.

The block has no streaming interface. `stall` is the only back-pressure it produces. It applies to the upstream fetch and decode registers, which the block does not own. The producer fields (valid, write enable, load flag, destination, result) are plain per-cycle inputs that the surrounding pipeline drives from its own stage registers.

Top module: `hz_bypass_ctl`

## Requirements
- R1: `sel_a` and `sel_b` use the code 0 for register file data, 1 for the execute result and 2 for the access result. The code 3 never appears. When no producer matches, the code is 0 and the register file data is used.
- R2: When the execute and access stages both write the requested register, the execute result is selected (code 1), because it is the younger producer.
- R3: A source register number of 0 never matches a producer. It always selects code 0 and never causes a stall.
- R4: When decode is valid and not stalled, the operand chosen in a cycle appears on `x_op_a` / `x_op_b` after the next rising clock edge, with `x_valid` high.
- R5: `stall` is high in exactly those cycles where decode is valid and the execute stage holds a valid, writing load whose non-zero destination equals either source. A load in the access stage does not cause a stall, and neither does a non-load in execute.
- R6: After a cycle with `stall` high, `bubble` is 1 and `x_valid` is 0. After any other cycle, `bubble` is 0 and `x_valid` equals the previous cycle's `d_valid`.
- R7: A stage whose valid or write enable is low never matches, for forwarding or for the interlock.
- R8: A load in execute is never a forwarding source. A dependent operand then falls through to the access stage match or to the register file.
- R9: While reset is asserted, `x_valid`, `bubble`, `x_op_a` and `x_op_b` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| d_valid | input | 1 | Decode stage holds an instruction |
| d_rs1 | input | REG_W | First source register number |
| d_rs2 | input | REG_W | Second source register number |
| rf_rdata1 | input | XLEN | Register file read data for d_rs1 |
| rf_rdata2 | input | XLEN | Register file read data for d_rs2 |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_W | Execute destination register |
| ex_result | input | XLEN | Execute stage result register |
| ma_valid | input | 1 | Access stage holds an instruction |
| ma_wen | input | 1 | Access instruction writes a register |
| ma_rd | input | REG_W | Access destination register |
| ma_result | input | XLEN | Access stage value (loaded or passed-on) |
| sel_a | output | 2 | Operand A source code (R1) |
| sel_b | output | 2 | Operand B source code (R1) |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble | output | 1 | Execute now holds an injected no-op |
| x_valid | output | 1 | Execute now holds a real instruction |
| x_op_a | output | XLEN | Registered ALU operand A |
| x_op_b | output | XLEN | Registered ALU operand B |

## Verification
The directed patterns cover three cases. The first is a subtract followed by a dependent AND, which must forward from execute. The second is a dependency two instructions apart, which must forward from access. The third is a load followed by its consumer, which must give exactly one bubble and then an access-stage forward; together these three separate the three mux legs from one another. Further vectors place the same destination in both stages to expose priority errors. Others name register 0 or clear valid or write enable, to catch false matches, and one puts a load in access or an unrelated load in execute, to catch stalls that should not happen. A long run of random producer and consumer fields, drawn from a small register range so that matches are frequent, is compared cycle by cycle against a behavioural model.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_EX = 2'd1,
    SRC_MA = 2'd2
  } src_sel_e;
endpackage

// File: rtl/hz_src_match.sv
// Per-source comparison against the two downstream producers.
module hz_src_match
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rs,
  input  logic             ex_valid,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ma_valid,
  input  logic             ma_wen,
  input  logic [REG_W-1:0] ma_rd,
  output src_sel_e         sel,
  output logic             load_hit
);
  logic rs_live;
  logic ex_hit;
  logic ma_hit;

  assign rs_live  = (rs != '0);
  assign ex_hit   = rs_live && ex_valid && ex_wen && (ex_rd == rs);
  assign ma_hit   = rs_live && ma_valid && ma_wen && (ma_rd == rs);
  assign load_hit = ex_hit && ex_load;

  always_comb begin
    if (ex_hit && !ex_load) begin
      sel = SRC_EX;
    end else if (ma_hit) begin
      sel = SRC_MA;
    end else begin
      sel = SRC_RF;
    end
  end
endmodule

// File: rtl/hz_opnd_mux.sv
// Three-way operand selector.
module hz_opnd_mux
  import hz_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  src_sel_e        sel,
  input  logic [XLEN-1:0] rf_data,
  input  logic [XLEN-1:0] ex_data,
  input  logic [XLEN-1:0] ma_data,
  output logic [XLEN-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SRC_EX:  opnd = ex_data;
      SRC_MA:  opnd = ma_data;
      default: opnd = rf_data;
    endcase
  end
endmodule

// File: rtl/hz_bypass_ctl.sv
// Decode-stage operand bypass selection and load-use interlock.
module hz_bypass_ctl
  import hz_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int REG_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic [REG_W-1:0] d_rs1,
  input  logic [REG_W-1:0] d_rs2,
  input  logic [XLEN-1:0]  rf_rdata1,
  input  logic [XLEN-1:0]  rf_rdata2,
  input  logic             ex_valid,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rd,
  input  logic [XLEN-1:0]  ex_result,
  input  logic             ma_valid,
  input  logic             ma_wen,
  input  logic [REG_W-1:0] ma_rd,
  input  logic [XLEN-1:0]  ma_result,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             stall,
  output logic             bubble,
  output logic             x_valid,
  output logic [XLEN-1:0]  x_op_a,
  output logic [XLEN-1:0]  x_op_b
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] rs_w    [NSRC];
  logic [XLEN-1:0]  rf_w    [NSRC];
  src_sel_e         sel_w   [NSRC];
  logic [XLEN-1:0]  opnd_w  [NSRC];
  logic [XLEN-1:0]  opnd_q  [NSRC];
  logic [NSRC-1:0]  ld_hit;
  logic             bubble_q;
  logic             xv_q;

  assign rs_w[0] = d_rs1;
  assign rs_w[1] = d_rs2;
  assign rf_w[0] = rf_rdata1;
  assign rf_w[1] = rf_rdata2;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hz_src_match #(.REG_W(REG_W)) u_match (
      .rs       (rs_w[s]),
      .ex_valid (ex_valid),
      .ex_wen   (ex_wen),
      .ex_load  (ex_load),
      .ex_rd    (ex_rd),
      .ma_valid (ma_valid),
      .ma_wen   (ma_wen),
      .ma_rd    (ma_rd),
      .sel      (sel_w[s]),
      .load_hit (ld_hit[s])
    );

    hz_opnd_mux #(.XLEN(XLEN)) u_mux (
      .sel     (sel_w[s]),
      .rf_data (rf_w[s]),
      .ex_data (ex_result),
      .ma_data (ma_result),
      .opnd    (opnd_w[s])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        opnd_q[s] <= '0;
      end else begin
        opnd_q[s] <= opnd_w[s];
      end
    end
  end

  assign stall = d_valid && (|ld_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xv_q     <= 1'b0;
      bubble_q <= 1'b0;
    end else begin
      xv_q     <= d_valid && !stall;
      bubble_q <= stall;
    end
  end

  assign sel_a   = sel_w[0];
  assign sel_b   = sel_w[1];
  assign x_valid = xv_q;
  assign bubble  = bubble_q;
  assign x_op_a  = opnd_q[0];
  assign x_op_b  = opnd_q[1];
endmodule

// File: rtl/hz_bypass_chk.sv
module hz_bypass_chk #(
  parameter int XLEN  = 32,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             d_valid,
  input logic [REG_W-1:0] d_rs1,
  input logic [REG_W-1:0] d_rs2,
  input logic             ex_valid,
  input logic             ex_wen,
  input logic             ex_load,
  input logic [REG_W-1:0] ex_rd,
  input logic [XLEN-1:0]  ex_result,
  input logic             ma_valid,
  input logic             ma_wen,
  input logic [REG_W-1:0] ma_rd,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             stall,
  input logic             bubble,
  input logic             x_valid,
  input logic [XLEN-1:0]  x_op_a
);
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'd3) && (sel_b != 2'd3)); // R1

  AST_EX_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_rs1 != '0) && ex_valid && ex_wen && !ex_load && (ex_rd == d_rs1)
     && ma_valid && ma_wen && (ma_rd == d_rs1)) |-> (sel_a == 2'd1)); // R2

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_rs1 == '0) |-> (sel_a == 2'd0)) and ((d_rs2 == '0) |-> (sel_b == 2'd0))); // R3

  AST_CAPTURE_EX: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !stall && (sel_a == 2'd1)) |=> (x_op_a == $past(ex_result))); // R4

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (d_valid && ex_valid && ex_wen && ex_load && (ex_rd != '0))); // R5

  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (bubble && !x_valid)); // R6

  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> !bubble); // R6

  AST_IDLE_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ex_valid || !ex_wen) && (!ma_valid || !ma_wen))
      |-> (sel_a == 2'd0 && sel_b == 2'd0 && !stall)); // R7

  AST_LOAD_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    ex_load |-> (sel_a != 2'd1 && sel_b != 2'd1)); // R8
endmodule

bind hz_bypass_ctl hz_bypass_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .d_valid   (d_valid),
  .d_rs1     (d_rs1),
  .d_rs2     (d_rs2),
  .ex_valid  (ex_valid),
  .ex_wen    (ex_wen),
  .ex_load   (ex_load),
  .ex_rd     (ex_rd),
  .ex_result (ex_result),
  .ma_valid  (ma_valid),
  .ma_wen    (ma_wen),
  .ma_rd     (ma_rd),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .stall     (stall),
  .bubble    (bubble),
  .x_valid   (x_valid),
  .x_op_a    (x_op_a)
);

// File: tb/test_hz_bypass_ctl.sv
`timescale 1ns/1ps
module test_hz_bypass_ctl;
  localparam int XLEN  = 32;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_valid = 0, ex_valid = 0, ex_wen = 0, ex_load = 0, ma_valid = 0, ma_wen = 0;
  logic [REG_W-1:0] d_rs1 = '0, d_rs2 = '0, ex_rd = '0, ma_rd = '0;
  logic [XLEN-1:0] rf_rdata1 = '0, rf_rdata2 = '0, ex_result = '0, ma_result = '0;
  logic [1:0] sel_a, sel_b;
  logic stall, bubble, x_valid;
  logic [XLEN-1:0] x_op_a, x_op_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hz_bypass_ctl #(.NREGS(32), .XLEN(XLEN)) i_hz_bypass_ctl (
    .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_rs1(d_rs1), .d_rs2(d_rs2),
    .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2),
    .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_load(ex_load), .ex_rd(ex_rd),
    .ex_result(ex_result), .ma_valid(ma_valid), .ma_wen(ma_wen), .ma_rd(ma_rd),
    .ma_result(ma_result), .sel_a(sel_a), .sel_b(sel_b), .stall(stall),
    .bubble(bubble), .x_valid(x_valid), .x_op_a(x_op_a), .x_op_b(x_op_b)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: source code for one operand.
  function automatic int ref_sel(input int rs);
    if (rs == 0) return 0;
    if (ex_valid && ex_wen && !ex_load && ex_rd == rs) return 1;
    if (ma_valid && ma_wen && ma_rd == rs) return 2;
    return 0;
  endfunction

  function automatic bit ref_stall();
    if (!d_valid || !ex_valid || !ex_wen || !ex_load || ex_rd == 0) return 0;
    return (ex_rd == d_rs1) || (ex_rd == d_rs2);
  endfunction

  function automatic logic [XLEN-1:0] pick(input int s, input logic [XLEN-1:0] rf);
    if (s == 1) return ex_result;
    if (s == 2) return ma_result;
    return rf;
  endfunction

  // Drive one cycle at the falling edge, check combinational outputs,
  // then check registered outputs just after the following rising edge.
  task automatic cyc(input string req,
                     input bit dv, input int rs1, input int rs2,
                     input bit exv, input bit exw, input bit exl, input int exrd,
                     input bit mav, input bit maw, input int mard);
    int sa, sb;
    bit st;
    logic [XLEN-1:0] ea, eb;
    d_valid = dv; d_rs1 = REG_W'(rs1); d_rs2 = REG_W'(rs2);
    ex_valid = exv; ex_wen = exw; ex_load = exl; ex_rd = REG_W'(exrd);
    ma_valid = mav; ma_wen = maw; ma_rd = REG_W'(mard);
    rf_rdata1 = $urandom; rf_rdata2 = $urandom;
    ex_result = $urandom; ma_result = $urandom;
    #1;
    sa = ref_sel(rs1); sb = ref_sel(rs2); st = ref_stall();
    ea = pick(sa, rf_rdata1); eb = pick(sb, rf_rdata2);
    chk(req, "sel_a", 64'(sel_a), 64'(sa));
    chk(req, "sel_b", 64'(sel_b), 64'(sb));
    chk(req, "stall", 64'(stall), 64'(st));
    @(posedge clk); #1;
    chk(req, "x_valid", 64'(x_valid), 64'(dv && !st));
    chk(req, "bubble", 64'(bubble), 64'(dv && st));
    if (dv && !st) begin
      chk(req, "x_op_a", 64'(x_op_a), 64'(ea));
      chk(req, "x_op_b", 64'(x_op_b), 64'(eb));
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "x_valid in reset", 64'(x_valid), 64'd0);
    chk("R9", "bubble in reset", 64'(bubble), 64'd0);
    chk("R9", "x_op_a in reset", 64'(x_op_a), 64'd0);
    chk("R9", "x_op_b in reset", 64'(x_op_b), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // No producers: register file data (R1)
    cyc("R1", 1, 3, 4, 0, 0, 0, 0, 0, 0, 0);
    // SUB r10 in execute, AND reads r10: execute forward (R1, R4)
    cyc("R4", 1, 10, 3, 1, 1, 0, 10, 0, 0, 0);
    // Producer two ahead, now in access: access forward (R1)
    cyc("R1", 1, 7, 10, 0, 0, 0, 0, 1, 1, 10);
    // Both stages write r6: execute wins (R2)
    cyc("R2", 1, 6, 6, 1, 1, 0, 6, 1, 1, 6);
    // Register 0 never matches (R3)
    cyc("R3", 1, 0, 0, 1, 1, 0, 0, 1, 1, 0);
    cyc("R3", 1, 0, 5, 1, 1, 1, 0, 0, 0, 0);
    // Invalid or non-writing stages never match (R7)
    cyc("R7", 1, 8, 9, 0, 1, 0, 8, 1, 0, 9);
    cyc("R7", 1, 8, 9, 1, 0, 1, 9, 0, 1, 8);
    // Load r5 in execute, consumer reads r5 on operand B: stall (R5)
    cyc("R5", 1, 2, 5, 1, 1, 1, 5, 0, 0, 0);
    // Held instruction retries, load now in access, bubble in execute (R6, R5)
    cyc("R6", 1, 2, 5, 0, 0, 0, 0, 1, 1, 5);
    // Load in execute with an older access producer of the same reg (R8)
    cyc("R8", 1, 12, 1, 1, 1, 1, 12, 1, 1, 12);
    cyc("R8", 0, 12, 1, 1, 1, 1, 12, 1, 1, 12);
    // Unrelated load in execute, and load in access only: no stall (R5)
    cyc("R5", 1, 4, 4, 1, 1, 1, 9, 0, 0, 0);
    cyc("R5", 1, 4, 4, 0, 0, 0, 0, 1, 1, 4);
    // Decode empty: no stall, x_valid low (R6)
    cyc("R6", 0, 4, 4, 1, 1, 1, 4, 0, 0, 0);

    // Random run over a small register range (R1..R8)
    for (int i = 0; i < 400; i++) begin
      cyc("R1-random", 1'($urandom_range(0, 3) != 0),
          $urandom_range(0, 3), $urandom_range(0, 3),
          1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3),
          1'($urandom), 1'($urandom), $urandom_range(0, 3));
    end

    // Reset in mid-run clears registered state (R9)
    cyc("R4", 1, 10, 0, 1, 1, 0, 10, 0, 0, 0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R9", "x_valid after reset", 64'(x_valid), 64'd0);
    chk("R9", "x_op_a after reset", 64'(x_op_a), 64'd0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule